// File: doc/BRIEF.md
# Dual-Mode GPIO Port Register Bank

This block holds the registers of one 8-bit general-purpose I/O port. A small register bus (address, write enable, write data, combinational read data) reaches three locations: a data latch, a direction latch and a read-only view of the pin levels. The pin side gets the latched output value and a per-pin output enable, and returns the raw pin levels. Those levels pass through a two-flop synchronizer before any read path sees them.

A global mode input selects how reads behave. With the mode low (legacy), a read of the data location returns a per-bit mix: the stored bit where the pin drives, and the synchronized pin level where the pin is an input. The pin-view location then reads zero. With the mode high, the data location returns only the stored value, and the pin-view location returns the synchronized pins.

Per-instance parameters mark reserved bits, which cannot be written and read as zero. Other parameters mark data bits whose reset value is taken from the pin level rather than zero.

Top module: `gpio_port_regs`

## Requirements
- R1: A bus write to address 0 (data) loads the write data into the data latch on the rising edge where write enable is high. The latch drives `port_out`. Every non-reserved bit not selected by the pin-load mask resets to 0.
- R2: With `mode_sel` = 0, a read of address 0 returns, per bit, the stored data bit where the direction bit is 1, and the synchronized pin level where the direction bit is 0.
- R3: With `mode_sel` = 1, a read of address 0 returns only the stored data value, whatever the pins and the direction.
- R4: A read of address 2 (pin view) returns the synchronized pin levels when `mode_sel` = 1, and 0 when `mode_sel` = 0.
- R5: A bus write to address 2 changes nothing: data, direction, `port_out` and `port_oe` keep their values.
- R6: Reserved bits (default: bit 7) cannot be written, and they read as 0 at every address. They are also 0 on `port_out` and `port_oe`.
- R7: Data bits selected by the pin-load mask (default: bit 6) take the synchronized pin level during reset, and hold the level seen in the last reset cycle.
- R8: Address 1 (direction) is read/write and resets to all zeros. `port_oe` follows it, with 1 meaning the pin drives.
- R9: A pin change becomes visible to reads after the second rising clock edge that follows it, and not after the first.
- R10: Reads are combinational from the address, with no clock needed. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Global read mode: 0 legacy mix, 1 separate pin view |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pin view, 3 unused |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Raw pin levels (asynchronous) |
| port_out | output | 8 | Latched output data toward the pads |
| port_oe | output | 8 | Per-pin output enable (direction) |

## Verification
The collision of interest is a bus write to the data latch landing on the same edge where the synchronizer's second stage delivers a new pin level, read back in legacy mode. The bench sets direction so that the low half of the port drives and the high half listens. It changes the pins one edge ahead and raises the write so that both updates meet on the next edge. The read just after that edge must show the new written bits in the low half and the new pin levels in the high half. The read just before that edge must still show the old values of both.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int BUS_ADDR_W = 2;

  typedef enum logic [BUS_ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PINS = 2'd2,
    SEL_NONE = 2'd3
  } gpio_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= raw_in;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) chain[s] <= chain[s-1];
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_port_store.sv
module gpio_port_store #(
  parameter int               WIDTH          = 8,
  parameter logic [WIDTH-1:0] RSVD_MASK      = '0,
  parameter logic [WIDTH-1:0] PIN_RESET_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data_en,
  input  logic             wr_dir_en,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);

  localparam logic [WIDTH-1:0] IMPL_MASK = ~RSVD_MASK;
  localparam logic [WIDTH-1:0] LOAD_MASK = PIN_RESET_MASK & IMPL_MASK;

  function automatic logic [WIDTH-1:0] keep_impl(input logic [WIDTH-1:0] v);
    return v & IMPL_MASK;
  endfunction

  function automatic logic [WIDTH-1:0] reset_image(input logic [WIDTH-1:0] pins);
    return pins & LOAD_MASK;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          data_q <= reset_image(pin_sync);
    else if (wr_data_en) data_q <= keep_impl(wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         dir_q <= '0;
    else if (wr_dir_en) dir_q <= keep_impl(wdata);
  end

  AST_RSVD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_q | dir_q) & RSVD_MASK) == '0) else $error("reserved bit set"); // R6

  AST_DIR_RESET: assert property (@(posedge clk)
    !rst_n |=> dir_q == '0) else $error("direction not cleared"); // R8

  AST_RESET_LOAD_ONLY: assert property (@(posedge clk)
    !rst_n |=> (data_q & ~LOAD_MASK) == '0) else $error("data reset value"); // R7

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_en |=> dir_q == ($past(wdata) & IMPL_MASK)) else $error("dir write"); // R8

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RSVD_MASK = '0
) (
  input  logic             mode_sel,
  input  gpio_sel_e        sel,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] rdata
);

  localparam logic [WIDTH-1:0] IMPL_MASK = ~RSVD_MASK;

  function automatic logic [WIDTH-1:0] blend(input logic [WIDTH-1:0] stored,
                                             input logic [WIDTH-1:0] pins,
                                             input logic [WIDTH-1:0] drives);
    return (stored & drives) | (pins & ~drives);
  endfunction

  logic [WIDTH-1:0] data_view;
  logic [WIDTH-1:0] pin_view;

  assign data_view = mode_sel ? data_q : blend(data_q, pin_sync, dir_q);
  assign pin_view  = mode_sel ? pin_sync : '0;

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = data_view & IMPL_MASK;
      SEL_DIR:  rdata = dir_q & IMPL_MASK;
      SEL_PINS: rdata = pin_view & IMPL_MASK;
      default:  rdata = '0;
    endcase
  end

  always_comb begin
    AST_RSVD_READ_ZERO: assert ((rdata & RSVD_MASK) == '0) else $error("reserved read"); // R6
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH          = 8,
  parameter int               SYNC_STAGES    = 2,
  parameter logic [WIDTH-1:0] RSVD_MASK      = 8'h80,
  parameter logic [WIDTH-1:0] PIN_RESET_MASK = 8'h40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_sel,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic [WIDTH-1:0]      pin_in,
  output logic [WIDTH-1:0]      port_out,
  output logic [WIDTH-1:0]      port_oe
);

  gpio_sel_e        sel;
  logic             wr_data_en;
  logic             wr_dir_en;
  logic             wr_pins_hit;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;

  assign sel         = gpio_sel_e'(bus_addr);
  assign wr_data_en  = bus_we && (sel == SEL_DATA);
  assign wr_dir_en   = bus_we && (sel == SEL_DIR);
  assign wr_pins_hit = bus_we && (sel == SEL_PINS);

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .raw_in   (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_store #(
    .WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK), .PIN_RESET_MASK(PIN_RESET_MASK)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_dir_en  (wr_dir_en),
    .wdata      (bus_wdata),
    .pin_sync   (pin_sync),
    .data_q     (data_q),
    .dir_q      (dir_q)
  );

  gpio_read_mux #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_rmux (
    .mode_sel (mode_sel),
    .sel      (sel),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign port_out = data_q;
  assign port_oe  = dir_q;

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> port_out == ($past(bus_wdata) & ~RSVD_MASK)) else $error("data write"); // R1

  AST_LEGACY_DRIVEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && sel == SEL_DATA) |-> ((bus_rdata ^ port_out) & port_oe) == '0)
    else $error("legacy mix"); // R2

  AST_NEW_MODE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && sel == SEL_DATA) |-> bus_rdata == port_out) else $error("new mode data"); // R3

  AST_LEGACY_PIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && sel == SEL_PINS) |-> bus_rdata == '0) else $error("pin view in legacy"); // R4

  AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pins_hit |=> $stable(port_out) && $stable(port_oe)) else $error("pin write had effect"); // R5

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> bus_rdata == '0) else $error("unused address"); // R10

endmodule

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/100ps
module gpio_port_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] port_out;
  logic [7:0] port_oe;

  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] IMPL = 8'h7F;

  always #2.5 clk = ~clk;

  gpio_port_regs uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .port_out(port_out), .port_oe(port_oe)
  );

  // {mode, dir written, data written, pins, expected data-address read}
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {8'h00, 8'hFF, 8'h5A, 8'h00, 8'h5A},
    {8'h00, 8'h00, 8'h5A, 8'h33, 8'h33},
    {8'h00, 8'h0F, 8'h3C, 8'h66, 8'h6C},
    {8'h01, 8'h0F, 8'h3C, 8'h66, 8'h3C},
    {8'h01, 8'h00, 8'h7F, 8'hFF, 8'h7F},
    {8'h00, 8'hF0, 8'hFF, 8'h81, 8'h71},
    {8'h00, 8'hAA, 8'h0F, 8'h55, 8'h5F},
    {8'h01, 8'hAA, 8'h0F, 8'h55, 8'h0F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset(input logic [7:0] pins);
    @(negedge clk);
    rst_n = 1'b0; pin_in = pins;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r, dsave, psave;

    // reset state with bit 6 pin high during reset
    do_reset(8'h40);
    mode_sel = 1'b1;
    rd(2'd0, r); check("R7 pin-loaded reset bit", r, 8'h40);
    check("R1 reset data port_out", port_out, 8'h40);
    rd(2'd1, r); check("R8 direction reset", r, 8'h00);
    check("R8 port_oe reset", port_oe, 8'h00);

    do_reset(8'h00);
    rd(2'd0, r); check("R7 R1 reset with pin low", r, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] m, d, w, p, e;
      {m, d, w, p, e} = VEC[i];
      wr(2'd1, d);
      wr(2'd0, w);
      pin_in = p; mode_sel = m[0];
      repeat (3) @(negedge clk);
      rd(2'd0, r); check(m[0] ? "R3 data read new mode" : "R2 data read legacy mix", r, e);
      rd(2'd2, r); check("R4 pin view", r, m[0] ? (p & IMPL) : 8'h00);
      rd(2'd1, r); check("R8 direction readback", r, d & IMPL);
      check("R8 port_oe", port_oe, d & IMPL);
      check("R1 R6 port_out", port_out, w & IMPL);
    end

    // R6: reserved bit not writable
    wr(2'd0, 8'hFF);
    rd(2'd0, r); check("R6 reserved data bit", r, 8'h7F);
    wr(2'd1, 8'h80);
    rd(2'd1, r); check("R6 reserved dir bit", r, 8'h00);

    // R5: write to pin view has no effect
    mode_sel = 1'b1;
    wr(2'd1, 8'h3C);
    wr(2'd0, 8'h21);
    dsave = port_out; psave = port_oe;
    wr(2'd2, 8'hFF);
    wr(2'd2, 8'h00);
    check("R5 port_out after pin write", port_out, dsave);
    check("R5 port_oe after pin write", port_oe, psave);
    rd(2'd0, r); check("R5 data after pin write", r, 8'h21);
    rd(2'd1, r); check("R5 dir after pin write", r, 8'h3C);

    // R9: two-flop latency
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_addr = 2'd2;
    pin_in = 8'h12;
    @(negedge clk);
    #0.5 check("R9 not visible after one edge", bus_rdata, 8'h00);
    @(negedge clk);
    #0.5 check("R9 visible after second edge", bus_rdata, 8'h12);

    // R10: combinational read, unused address
    @(negedge clk);
    bus_addr = 2'd1;
    #0.5 check("R10 comb read dir", bus_rdata, 8'h3C);
    bus_addr = 2'd3;
    #0.5 check("R10 unused address", bus_rdata, 8'h00);
    bus_addr = 2'd0;
    #0.5 check("R10 comb read data", bus_rdata, 8'h21);

    // same-cycle: data write meets pin delivery, legacy mode
    mode_sel = 1'b0;
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h30;
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h05; bus_we = 1'b1;
    #0.5 check("R2 before collision edge", bus_rdata, 8'h00);
    @(negedge clk);
    bus_we = 1'b0;
    #0.5 check("R2 R1 write and pin on same edge", bus_rdata, 8'h35);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule